// File: doc/BRIEF.md
# Carrier-Sense Transmit Arbiter with Acknowledgement Window

This block decides when a node sharing a single-wire or optical medium may start sending a frame, and then follows the optional one-byte reply from the recipient. A request strobe starts a sensing interval. During that interval the line must stay at logic 0 and the receiver must report no bytes. The interval is the response timeout shared by all nodes plus a small pseudo-random extra. If the medium stays quiet for longer than that, the block pulses a grant to the transmitter. If anything is heard, the attempt is dropped and a busy pulse is reported. The attempt is not deferred and retried: that choice is left to the layer above.

After the transmitter signals that the frame is out, the block either returns to idle or opens a reply window, according to the acknowledgement flag latched with the request. The reply window lasts as long as the same response timeout. An acknowledgement byte inside the window gives a success pulse. A wrong byte, or no byte at all, gives a failure pulse. While the frame is going out, a loss-of-synchronisation report from the receiver is taken to mean that another master started at the same instant, and it gives a collision pulse. Bit timing, byte stuffing and frame checking are done outside this block.

Top module: `csma_link_arbiter`

## Requirements
- R1: After reset the block is idle, and grant_o, busy_o, ack_ok_o, ack_fail_o and collision_o are all 0.
- R2: The block accepts req_i only while idle. A request made while a previous attempt is sensing, transmitting or waiting for a reply is dropped: it changes neither the acknowledgement flag of that attempt nor the number of grants.
- R3: A 16-bit LFSR reloads to 16'hACE1 on reset and shifts left on every clock, taking in bit 15 ^ bit 13 ^ bit 12 ^ bit 10. At the clock edge where a request is accepted, the threshold T is set to RESP_TIMEOUT plus the low RAND_BITS bits of the LFSR. Sensing then starts at the next edge. If line_i is 0 and rx_valid_i is 0 at the T+1 sensing edges numbered 0 to T, grant_o is 1 for exactly one cycle after sensing edge T.
- R4: If line_i is 1 or rx_valid_i is 1 at any sensing edge, including edge T, busy_o is 1 for one cycle and the block returns to idle. The block does not retry: no grant follows until a new request arrives.
- R5: If the request had ack_req_i at 0, a tx_done_i pulse after the grant returns the block to idle, and neither acknowledgement output is raised.
- R6: If the request had ack_req_i at 1, a tx_done_i pulse opens a reply window of RESP_TIMEOUT edges, numbered 0 to RESP_TIMEOUT-1 and starting at the next edge. A received byte of 8'h06 inside the window gives ack_ok_o for one cycle.
- R7: A received byte of any other value inside the reply window gives ack_fail_o for one cycle and closes the window.
- R8: If no byte arrives inside the reply window, ack_fail_o is 1 for one cycle after window edge RESP_TIMEOUT-1. A byte that arrives later is ignored.
- R9: If sync_lost_i is 1 while the block waits for tx_done_i, collision_o is 1 for one cycle and the block returns to idle without opening a reply window.
- R10: At most one of grant_o, busy_o, ack_ok_o, ack_fail_o and collision_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled medium level, 1 = activity |
| req_i | input | 1 | Frame request strobe |
| ack_req_i | input | 1 | Reply wanted for this request; sampled together with req_i |
| rx_valid_i | input | 1 | Strobe from the receiver: a byte has been received |
| rx_byte_i | input | 8 | Received byte value |
| sync_lost_i | input | 1 | Receiver reports loss of synchronisation |
| tx_done_i | input | 1 | Transmitter reports that the frame has been sent |
| grant_o | output | 1 | One-cycle permission to start sending |
| busy_o | output | 1 | One-cycle pulse: attempt dropped because the medium is in use |
| ack_ok_o | output | 1 | One-cycle pulse: acknowledgement received |
| ack_fail_o | output | 1 | One-cycle pulse: wrong reply or reply window expired |
| collision_o | output | 1 | One-cycle pulse: collision detected while sending |

## Verification
The bench drives line activity on the very last sensing edge, where T comes from the bench's own LFSR. A design that counted one edge short would grant there instead of reporting busy. Replies are placed on the last edge of the window and on the edge after it. An off-by-one window would flip that first reply from success to failure, or accept the late byte. Second requests are made while an attempt is in progress, so a design that re-latched them would pick up the wrong acknowledgement flag or grant twice. After every busy pulse the line is held quiet for a long time, and a persistent design would then grant without being asked.

// File: rtl/csma_arb_pkg.sv
package csma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SENSE = 2'd1,
        ST_XMIT  = 2'd2,
        ST_RESP  = 2'd3
    } arb_state_e;

    localparam logic [7:0]  ACK_CODE  = 8'h06;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    import csma_arb_pkg::*;

    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LFSR_SEED;
        else        state_q <= state_d;
    end

    assign rnd_o = state_q[OUT_W-1:0];

    assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'h0000);

endmodule

// File: rtl/csma_tick_counter.sv
module csma_tick_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)     cnt_d = '0;
        else if (en_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/csma_link_arbiter.sv
module csma_link_arbiter #(
    parameter int RESP_TIMEOUT = 40,
    parameter int RAND_BITS    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       req_i,
    input  logic       ack_req_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       sync_lost_i,
    input  logic       tx_done_i,
    output logic       grant_o,
    output logic       busy_o,
    output logic       ack_ok_o,
    output logic       ack_fail_o,
    output logic       collision_o
);
    import csma_arb_pkg::*;

    localparam int EXTRA_MAX = (1 << RAND_BITS) - 1;
    localparam int THR_MAX   = RESP_TIMEOUT + EXTRA_MAX;
    localparam int CNT_W     = $clog2(THR_MAX + 1);
    localparam logic [CNT_W-1:0] RESP_LAST = CNT_W'(RESP_TIMEOUT - 1);

    typedef struct packed {
        arb_state_e       st;
        logic [CNT_W-1:0] thr;
        logic             want_ack;
        logic             grant;
        logic             busy;
        logic             ok;
        logic             fail;
        logic             coll;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [RAND_BITS-1:0] rnd;
    logic [CNT_W-1:0]     cnt;
    logic                 cnt_clr, cnt_en;

    csma_lfsr #(.OUT_W(RAND_BITS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    csma_tick_counter #(.W(CNT_W)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .en_i    (cnt_en),
        .count_o (cnt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.grant = 1'b0;
        r_d.busy  = 1'b0;
        r_d.ok    = 1'b0;
        r_d.fail  = 1'b0;
        r_d.coll  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_en    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.st       = ST_SENSE;
                    r_d.thr      = CNT_W'(RESP_TIMEOUT) + CNT_W'(rnd);
                    r_d.want_ack = ack_req_i;
                    cnt_clr      = 1'b1;
                end
            end
            ST_SENSE: begin
                if (line_i || rx_valid_i) begin
                    r_d.busy = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (cnt == r_q.thr) begin
                    r_d.grant = 1'b1;
                    r_d.st    = ST_XMIT;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_XMIT: begin
                if (sync_lost_i) begin
                    r_d.coll = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (tx_done_i) begin
                    if (r_q.want_ack) begin
                        r_d.st  = ST_RESP;
                        cnt_clr = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_RESP: begin
                if (rx_valid_i) begin
                    r_d.ok   = (rx_byte_i == ACK_CODE);
                    r_d.fail = (rx_byte_i != ACK_CODE);
                    r_d.st   = ST_IDLE;
                end else if (cnt == RESP_LAST) begin
                    r_d.fail = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, thr: '0, want_ack: 1'b0, grant: 1'b0,
                     busy: 1'b0, ok: 1'b0, fail: 1'b0, coll: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign grant_o     = r_q.grant;
    assign busy_o      = r_q.busy;
    assign ack_ok_o    = r_q.ok;
    assign ack_fail_o  = r_q.fail;
    assign collision_o = r_q.coll;

    assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o}));

    assert_grant_after_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(!line_i && !rx_valid_i && cnt == r_q.thr));

    assert_grant_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> !grant_o);

    assert_busy_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $past(line_i || rx_valid_i));

    assert_ack_ok_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok_o |-> $past(rx_valid_i && rx_byte_i == ACK_CODE));

    assert_fail_from_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fail_o |-> $past(r_q.st == ST_RESP));

    assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESP) |-> (cnt <= RESP_LAST));

    assert_collision_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        collision_o |-> $past(sync_lost_i && r_q.st == ST_XMIT));

endmodule

// File: tb/csma_link_arbiter_tb_top.sv
module csma_link_arbiter_tb_top;
    localparam int TO   = 40;
    localparam int RB   = 3;
    localparam int MASK = (1 << RB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = 1'b0, req_i = 1'b0, ack_req_i = 1'b0, rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic sync_lost_i = 1'b0, tx_done_i = 1'b0;
    logic grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o;

    always #10 clk = ~clk;

    csma_link_arbiter #(.RESP_TIMEOUT(TO), .RAND_BITS(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .req_i(req_i),
        .ack_req_i(ack_req_i), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .sync_lost_i(sync_lost_i), .tx_done_i(tx_done_i),
        .grant_o(grant_o), .busy_o(busy_o), .ack_ok_o(ack_ok_o),
        .ack_fail_o(ack_fail_o), .collision_o(collision_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int g_cnt = 0, b_cnt = 0, ok_cnt = 0, f_cnt = 0, c_cnt = 0;

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 listening, 2 sending, 3 awaiting reply
    int          m_phase = 0;
    int          m_ticks = 0;
    int          m_thr   = 0;
    bit          m_ack   = 0;
    logic [15:0] m_lfsr  = 16'hACE1;
    bit e_grant = 0, e_busy = 0, e_ok = 0, e_fail = 0, e_coll = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ticks = 0; m_thr = 0; m_ack = 0; m_lfsr = 16'hACE1;
            e_grant = 0; e_busy = 0; e_ok = 0; e_fail = 0; e_coll = 0;
        end else begin
            e_grant = 0; e_busy = 0; e_ok = 0; e_fail = 0; e_coll = 0;
            if (m_phase == 0) begin
                if (req_i) begin
                    m_phase = 1; m_ticks = 0; m_ack = ack_req_i;
                    m_thr = TO + int'(m_lfsr) % (MASK + 1);
                end
            end else if (m_phase == 1) begin
                if (line_i || rx_valid_i) begin
                    e_busy = 1; m_phase = 0;
                end else if (m_ticks >= m_thr) begin
                    e_grant = 1; m_phase = 2;
                end else m_ticks++;
            end else if (m_phase == 2) begin
                if (sync_lost_i) begin
                    e_coll = 1; m_phase = 0;
                end else if (tx_done_i) begin
                    m_phase = m_ack ? 3 : 0; m_ticks = 0;
                end
            end else begin
                if (rx_valid_i) begin
                    if (rx_byte_i == 8'h06) e_ok = 1; else e_fail = 1;
                    m_phase = 0;
                end else if (m_ticks == TO - 1) begin
                    e_fail = 1; m_phase = 0;
                end else m_ticks++;
            end
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(grant_o == e_grant, "R3", "grant_o", grant_o, e_grant);
            chk(busy_o == e_busy, "R4", "busy_o", busy_o, e_busy);
            chk(ack_ok_o == e_ok, "R6", "ack_ok_o", ack_ok_o, e_ok);
            chk(ack_fail_o == e_fail, "R8", "ack_fail_o", ack_fail_o, e_fail);
            chk(collision_o == e_coll, "R9", "collision_o", collision_o, e_coll);
            chk($countones({grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o}) <= 1,
                "R10", "active pulses", $countones({grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o}), 1);
            g_cnt += grant_o; b_cnt += busy_o; ok_cnt += ack_ok_o;
            f_cnt += ack_fail_o; c_cnt += collision_o;
        end
    end

    task automatic pulse_req(input bit want_ack);
        @(negedge clk); req_i = 1'b1; ack_req_i = want_ack;
        @(negedge clk); req_i = 1'b0; ack_req_i = 1'b0;
    endtask

    task automatic wait_grant(input string req);
        bit seen = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (grant_o) begin seen = 1; break; end
        end
        chk(seen, req, "grant seen", seen, 1);
    endtask

    task automatic send_done();
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic settle(); #1; endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int g0, b0, ok0, f0, c0;
        repeat (3) @(negedge clk);
        chk({grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o} == 5'b0, "R1",
            "outputs in reset", {grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o} == 5'b0, "R1",
            "outputs after reset", {grant_o, busy_o, ack_ok_o, ack_fail_o, collision_o}, 0);

        // R3 / R5: quiet line, no reply wanted
        g0 = g_cnt; ok0 = ok_cnt; f0 = f_cnt;
        pulse_req(1'b0);
        wait_grant("R3");
        send_done();
        repeat (TO + 10) @(negedge clk); settle();
        chk(g_cnt == g0 + 1, "R3", "grants", g_cnt - g0, 1);
        chk(ok_cnt == ok0 && f_cnt == f0, "R5", "ack pulses", ok_cnt + f_cnt - ok0 - f0, 0);

        // R4: line active mid-sense, then a long quiet spell with no retry
        g0 = g_cnt; b0 = b_cnt;
        pulse_req(1'b0);
        repeat (10) @(negedge clk);
        line_i = 1'b1; @(negedge clk); line_i = 1'b0;
        repeat (100) @(negedge clk); settle();
        chk(b_cnt == b0 + 1, "R4", "busy on line", b_cnt - b0, 1);
        chk(g_cnt == g0, "R4", "no retry grant", g_cnt - g0, 0);

        // R4: receiver byte during sensing
        b0 = b_cnt;
        pulse_req(1'b1);
        repeat (5) @(negedge clk);
        send_byte(8'h06);
        repeat (5) @(negedge clk); settle();
        chk(b_cnt == b0 + 1, "R4", "busy on rx byte", b_cnt - b0, 1);

        // R4: line already high at the first sensing edge
        b0 = b_cnt;
        @(negedge clk); req_i = 1'b1;
        @(negedge clk); req_i = 1'b0; line_i = 1'b1;
        @(negedge clk); line_i = 1'b0;
        repeat (3) @(negedge clk); settle();
        chk(b_cnt == b0 + 1, "R4", "busy at first edge", b_cnt - b0, 1);

        // R3 / R4 boundary: activity on the last sensing edge T
        g0 = g_cnt; b0 = b_cnt;
        pulse_req(1'b0);
        repeat (m_thr) @(negedge clk);
        line_i = 1'b1; @(negedge clk); line_i = 1'b0;
        repeat (60) @(negedge clk); settle();
        chk(b_cnt == b0 + 1, "R4", "busy at last edge", b_cnt - b0, 1);
        chk(g_cnt == g0, "R3", "no grant at last edge", g_cnt - g0, 0);

        // R6: correct reply inside the window
        ok0 = ok_cnt;
        pulse_req(1'b1); wait_grant("R6"); send_done();
        repeat (5) @(negedge clk);
        send_byte(8'h06);
        repeat (3) @(negedge clk); settle();
        chk(ok_cnt == ok0 + 1, "R6", "ack ok", ok_cnt - ok0, 1);

        // R7: wrong reply byte
        ok0 = ok_cnt; f0 = f_cnt;
        pulse_req(1'b1); wait_grant("R7"); send_done();
        repeat (8) @(negedge clk);
        send_byte(8'h15);
        repeat (TO) @(negedge clk); settle();
        chk(f_cnt == f0 + 1 && ok_cnt == ok0, "R7", "fail on wrong byte", f_cnt - f0, 1);

        // R8: silence until the window closes
        f0 = f_cnt;
        pulse_req(1'b1); wait_grant("R8"); send_done();
        repeat (TO + 5) @(negedge clk); settle();
        chk(f_cnt == f0 + 1, "R8", "timeout fail", f_cnt - f0, 1);

        // R8 boundary: reply on window edge TO-1 still counts
        ok0 = ok_cnt; f0 = f_cnt;
        pulse_req(1'b1); wait_grant("R8"); send_done();
        repeat (TO - 1) @(negedge clk);
        send_byte(8'h06);
        repeat (3) @(negedge clk); settle();
        chk(ok_cnt == ok0 + 1 && f_cnt == f0, "R8", "reply on last edge", ok_cnt - ok0, 1);

        // R8 boundary: reply one edge late is ignored
        ok0 = ok_cnt; f0 = f_cnt;
        pulse_req(1'b1); wait_grant("R8"); send_done();
        repeat (TO) @(negedge clk);
        send_byte(8'h06);
        repeat (3) @(negedge clk); settle();
        chk(ok_cnt == ok0 && f_cnt == f0 + 1, "R8", "late reply fail", f_cnt - f0, 1);

        // R9: collision while sending; later done opens nothing
        c0 = c_cnt; ok0 = ok_cnt; f0 = f_cnt;
        pulse_req(1'b1); wait_grant("R9");
        @(negedge clk); sync_lost_i = 1'b1;
        @(negedge clk); sync_lost_i = 1'b0;
        send_done();
        repeat (TO + 5) @(negedge clk); settle();
        chk(c_cnt == c0 + 1, "R9", "collision", c_cnt - c0, 1);
        chk(ok_cnt == ok0 && f_cnt == f0, "R9", "no reply window", ok_cnt + f_cnt - ok0 - f0, 0);

        // R2: second request during sensing keeps the first ack flag
        g0 = g_cnt; f0 = f_cnt;
        pulse_req(1'b1);
        repeat (3) @(negedge clk);
        pulse_req(1'b0);
        wait_grant("R2");
        send_done();
        repeat (TO + 5) @(negedge clk); settle();
        chk(f_cnt == f0 + 1, "R2", "first ack flag kept", f_cnt - f0, 1);
        chk(g_cnt == g0 + 1, "R2", "single grant", g_cnt - g0, 1);

        // R2: request while sending is dropped
        g0 = g_cnt;
        pulse_req(1'b0); wait_grant("R2");
        pulse_req(1'b0);
        send_done();
        repeat (100) @(negedge clk); settle();
        chk(g_cnt == g0 + 1, "R2", "request in send dropped", g_cnt - g0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule